// File: doc/BRIEF.md
# Radio Slot Sequencing Controller

This block sits on the host side of a 2.4 GHz radio front end and carries it through one transmit or receive slot per request. A start pulse captures the slot type, an 8-bit synthesizer channel code, an output-power ramp level, a deviation trim and a clock-recovery option. The controller then raises the regulator and transceiver power lines and waits for the supplies to settle. It serialises a configuration frame on a three-wire bus (clock, data, active-low enable) and waits for the synthesizer to lock once enable returns high. After that it opens the slot.

In a transmit slot the transmit-enable line rises. The open-loop enable line is pulled low in the cycle after the host signals that modulation data is flowing. In a receive slot only the receive-enable line rises. An end-of-slot pulse first drops the enable lines and restores open-loop enable. One cycle later it drops both power lines. Every wait is a counter loaded from parameters given in microseconds and cycles per microsecond, so the same RTL serves any system clock.

Top module: `slotseq_ctrl`

## Requirements
- R1: After reset both power lines, both enable lines, bus clock and busy are low, while open-loop enable and bus enable are high.
- R2: A start pulse while idle raises both power lines and busy. The bus enable stays high for at least SETTLE_US×CYC_PER_US cycles and at most 3 cycles more.
- R3: A transmit frame is 16 bits: [15:14]=01, [13:12]=ramp level, [11:9]=deviation trim, [8]=1, [7:0]=channel code. The clock-recovery option has no effect on it.
- R4: A receive frame without clock recovery is 16 bits: [15:14]=01, [13:8]=0, [7:0]=channel code.
- R5: A receive frame with clock recovery is 25 bits: [24:16]=101000000, [15:8]=0, [7:0]=channel code.
- R6: Frames go out MSB first, one bit per rising bus clock edge. Data is stable while the clock is high and in the sample after it falls. Each high phase lasts at least BUS_HALF cycles and each low phase at least BUS_HALF cycles. Enable falls at least ENA_LEAD cycles before the first rising edge, and the clock is low when enable rises.
- R7: After bus enable rises, the slot enable line follows no sooner than PLL_US×CYC_PER_US cycles and no later than 3 cycles after that.
- R8: A transmit slot raises only transmit-enable. Open-loop enable stays high until the data-start input is seen, goes low one cycle later and stays low until the slot ends.
- R9: A receive slot raises only receive-enable. The data-start input leaves open-loop enable high.
- R10: One cycle after an end-of-slot pulse, the enable lines are low and open-loop enable is high while power is still on. One cycle after that, both power lines and busy are low.
- R11: A start pulse while busy is ignored. It changes neither the running slot nor the state after that slot, so no new power-up follows.
- R12: Slot-active is high exactly while one of the two slot enable lines is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Slot request pulse, taken only when idle |
| slot_tx | input | 1 | 1 = transmit slot, 0 = receive slot |
| clk_recov | input | 1 | Receive with clock recovery (25-bit frame) |
| chan_code | input | 8 | Reference select, main and swallow counter settings |
| pa_level | input | 2 | External amplifier ramp level (transmit only) |
| dev_trim | input | 3 | Deviation trim (transmit only) |
| tx_data_go | input | 1 | Modulation data has started |
| slot_end | input | 1 | Ends the active slot |
| pwr_reg_en | output | 1 | Regulator power-up line |
| pwr_trx_en | output | 1 | Transceiver power-up line |
| rx_en | output | 1 | Receive enable |
| tx_en | output | 1 | Transmit enable, also starts the power ramp |
| open_loop_n | output | 1 | Open-loop enable, low = open-loop modulation |
| bus_clk | output | 1 | Three-wire bus clock |
| bus_dat | output | 1 | Three-wire bus data |
| bus_en_n | output | 1 | Three-wire bus enable, active low |
| busy | output | 1 | A slot sequence is in progress |
| slot_active | output | 1 | Slot enable line is asserted |

## Verification
Power is due one cycle after the start pulse is sampled. Bus enable falls SETTLE+1 cycles after power rises, and the slot enable rises PLL+1 cycles after bus enable returns high. The bench checks both intervals against a window of the minimum plus three cycles. Open-loop enable, the enable drop and the power drop are each due exactly one cycle after their input pulse, and the bench samples them at the first falling clock edge after the capturing edge. Frames are rebuilt bit by bit at every rising bus clock. Phase lengths are counted in whole cycles and compared against the minimums from the bus parameters.

// File: rtl/slotseq_pkg.sv
package slotseq_pkg;

    localparam int FRAME_MAX   = 25;
    localparam int FRAME_SHORT = 16;
    localparam int LEN_W       = $clog2(FRAME_MAX + 1);

    localparam logic [8:0] RECOV_PREFIX = 9'b101000000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_PROG,
        ST_PLL,
        ST_ACTIVE,
        ST_RELEASE
    } seq_state_e;

    typedef enum logic [2:0] {
        SB_IDLE,
        SB_LEAD,
        SB_LOW,
        SB_HIGH,
        SB_HOLD,
        SB_TAIL
    } bus_state_e;

    typedef struct packed {
        logic       is_tx;
        logic       recov;
        logic [1:0] pa;
        logic [2:0] dev;
        logic [7:0] chan;
    } slot_req_t;

    function automatic logic [FRAME_MAX-1:0] build_word(slot_req_t r);
        logic [FRAME_MAX-1:0] w;
        w = '0;
        w[7:0] = r.chan;
        if (r.is_tx) begin
            w[15:14] = 2'b01;
            w[13:12] = r.pa;
            w[11:9]  = r.dev;
            w[8]     = 1'b1;
        end else if (r.recov) begin
            w[24:16] = RECOV_PREFIX;
        end else begin
            w[15:14] = 2'b01;
        end
        return w;
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(slot_req_t r);
        return (!r.is_tx && r.recov) ? LEN_W'(FRAME_MAX) : LEN_W'(FRAME_SHORT);
    endfunction

endpackage

// File: rtl/slotseq_wait.sv
module slotseq_wait #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/slotseq_serial.sv
module slotseq_serial
    import slotseq_pkg::*;
#(
    parameter int BUS_HALF = 8,
    parameter int BUS_HOLD = 3,
    parameter int ENA_LEAD = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [FRAME_MAX-1:0] word,
    input  logic [LEN_W-1:0]     nbits,
    output logic                 sclk,
    output logic                 sdat,
    output logic                 sen_n,
    output logic                 done
);
    localparam int CMAX = (ENA_LEAD > BUS_HALF) ?
                          ((ENA_LEAD > BUS_HOLD) ? ENA_LEAD : BUS_HOLD) :
                          ((BUS_HALF > BUS_HOLD) ? BUS_HALF : BUS_HOLD);
    localparam int CW = $clog2(CMAX + 1);

    bus_state_e           st;
    logic [CW-1:0]        cnt;
    logic [FRAME_MAX-1:0] sh;
    logic [LEN_W-1:0]     left;

    assign sdat = sh[FRAME_MAX-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SB_IDLE;
            cnt   <= '0;
            sh    <= '0;
            left  <= '0;
            sclk  <= 1'b0;
            sen_n <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SB_IDLE: begin
                    if (go) begin
                        sh    <= word << (LEN_W'(FRAME_MAX) - nbits);
                        left  <= nbits;
                        sen_n <= 1'b0;
                        cnt   <= CW'(ENA_LEAD - 1);
                        st    <= SB_LEAD;
                    end
                end
                SB_LEAD: begin
                    if (cnt == '0) begin
                        cnt <= CW'(BUS_HALF - 1);
                        st  <= SB_LOW;
                    end else cnt <= cnt - 1'b1;
                end
                SB_LOW: begin
                    if (cnt == '0) begin
                        sclk <= 1'b1;
                        cnt  <= CW'(BUS_HALF - 1);
                        st   <= SB_HIGH;
                    end else cnt <= cnt - 1'b1;
                end
                SB_HIGH: begin
                    if (cnt == '0) begin
                        sclk <= 1'b0;
                        left <= left - 1'b1;
                        if (left == LEN_W'(1)) begin
                            cnt <= CW'(BUS_HALF - 1);
                            st  <= SB_TAIL;
                        end else begin
                            cnt <= CW'(BUS_HOLD - 1);
                            st  <= SB_HOLD;
                        end
                    end else cnt <= cnt - 1'b1;
                end
                SB_HOLD: begin
                    if (cnt == '0) begin
                        sh  <= sh << 1;
                        cnt <= CW'(BUS_HALF - 1);
                        st  <= SB_LOW;
                    end else cnt <= cnt - 1'b1;
                end
                SB_TAIL: begin
                    if (cnt == '0) begin
                        sen_n <= 1'b1;
                        done  <= 1'b1;
                        st    <= SB_IDLE;
                    end else cnt <= cnt - 1'b1;
                end
                default: st <= SB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/slotseq_ctrl.sv
module slotseq_ctrl
    import slotseq_pkg::*;
#(
    parameter int CYC_PER_US = 125,
    parameter int SETTLE_US  = 40,
    parameter int PLL_US     = 350,
    parameter int BUS_HALF   = 8,
    parameter int BUS_HOLD   = 3,
    parameter int ENA_LEAD   = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       slot_tx,
    input  logic       clk_recov,
    input  logic [7:0] chan_code,
    input  logic [1:0] pa_level,
    input  logic [2:0] dev_trim,
    input  logic       tx_data_go,
    input  logic       slot_end,
    output logic       pwr_reg_en,
    output logic       pwr_trx_en,
    output logic       rx_en,
    output logic       tx_en,
    output logic       open_loop_n,
    output logic       bus_clk,
    output logic       bus_dat,
    output logic       bus_en_n,
    output logic       busy,
    output logic       slot_active
);
    localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
    localparam int PLL_CYC    = CYC_PER_US * PLL_US;
    localparam int WMAX       = (SETTLE_CYC > PLL_CYC) ? SETTLE_CYC : PLL_CYC;
    localparam int TW         = $clog2(WMAX + 1);

    seq_state_e state;
    slot_req_t  req;
    logic       ser_go;
    logic       ser_done;
    logic       ol_n;
    logic       t_load;
    logic       t_zero;
    logic [TW-1:0] t_val;

    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        if (state == ST_IDLE && start) begin
            t_load = 1'b1;
            t_val  = TW'(SETTLE_CYC - 1);
        end else if (state == ST_PROG && ser_done) begin
            t_load = 1'b1;
            t_val  = TW'(PLL_CYC - 1);
        end
    end

    slotseq_wait #(.W(TW)) u_wait (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .val  (t_val),
        .zero (t_zero)
    );

    slotseq_serial #(
        .BUS_HALF (BUS_HALF),
        .BUS_HOLD (BUS_HOLD),
        .ENA_LEAD (ENA_LEAD)
    ) u_serial (
        .clk   (clk),
        .rst   (rst),
        .go    (ser_go),
        .word  (build_word(req)),
        .nbits (frame_len(req)),
        .sclk  (bus_clk),
        .sdat  (bus_dat),
        .sen_n (bus_en_n),
        .done  (ser_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            req    <= '0;
            ser_go <= 1'b0;
            ol_n   <= 1'b1;
        end else begin
            ser_go <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req.is_tx <= slot_tx;
                        req.recov <= clk_recov;
                        req.pa    <= pa_level;
                        req.dev   <= dev_trim;
                        req.chan  <= chan_code;
                        state     <= ST_PWRUP;
                    end
                end
                ST_PWRUP: begin
                    if (t_zero) begin
                        ser_go <= 1'b1;
                        state  <= ST_PROG;
                    end
                end
                ST_PROG: begin
                    if (ser_done) state <= ST_PLL;
                end
                ST_PLL: begin
                    if (t_zero) state <= ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (slot_end) begin
                        ol_n  <= 1'b1;
                        state <= ST_RELEASE;
                    end else if (req.is_tx && tx_data_go) begin
                        ol_n <= 1'b0;
                    end
                end
                ST_RELEASE: state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    assign pwr_reg_en  = (state != ST_IDLE);
    assign pwr_trx_en  = (state != ST_IDLE);
    assign busy        = (state != ST_IDLE);
    assign slot_active = (state == ST_ACTIVE);
    assign tx_en       = (state == ST_ACTIVE) &&  req.is_tx;
    assign rx_en       = (state == ST_ACTIVE) && !req.is_tx;
    assign open_loop_n = ol_n;
endmodule

// File: rtl/slotseq_ctrl_chk.sv
module slotseq_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic pwr_reg_en,
    input logic pwr_trx_en,
    input logic rx_en,
    input logic tx_en,
    input logic open_loop_n,
    input logic bus_clk,
    input logic bus_dat,
    input logic bus_en_n,
    input logic slot_active
);
    AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rx_en && tx_en)); // R9

    AST_OPEN_LOOP_NEEDS_TX: assert property (@(posedge clk) disable iff (rst)
        !open_loop_n |-> tx_en); // R8

    AST_ENABLE_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
        (rx_en || tx_en) |-> (pwr_reg_en && pwr_trx_en)); // R10

    AST_BUS_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
        !bus_en_n |-> pwr_trx_en); // R2

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (bus_clk && $past(bus_clk)) |-> $stable(bus_dat)); // R6

    AST_DATA_HOLD_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_clk) |-> $stable(bus_dat)); // R6

    AST_LATCH_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_en_n) |-> !bus_clk); // R6

    AST_ACTIVE_MATCH: assert property (@(posedge clk) disable iff (rst)
        slot_active == (rx_en || tx_en)); // R12

    AST_POWER_DROP_ORDER: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_trx_en) |-> $past(!rx_en && !tx_en && open_loop_n)); // R10
endmodule

bind slotseq_ctrl slotseq_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_reg_en  (pwr_reg_en),
    .pwr_trx_en  (pwr_trx_en),
    .rx_en       (rx_en),
    .tx_en       (tx_en),
    .open_loop_n (open_loop_n),
    .bus_clk     (bus_clk),
    .bus_dat     (bus_dat),
    .bus_en_n    (bus_en_n),
    .slot_active (slot_active)
);

// File: tb/slotseq_ctrl_test.sv
module slotseq_ctrl_test;
    localparam int CPU = 1, SET_US = 40, PLL_US = 350;
    localparam int HALF = 8, HOLD = 3, LEAD = 13;
    localparam int SET_C = CPU * SET_US, PLL_C = CPU * PLL_US;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 0, slot_tx = 0, clk_recov = 0, tx_data_go = 0, slot_end = 0;
    logic [7:0] chan_code = 0;
    logic [1:0] pa_level = 0;
    logic [2:0] dev_trim = 0;
    logic pwr_reg_en, pwr_trx_en, rx_en, tx_en, open_loop_n;
    logic bus_clk, bus_dat, bus_en_n, busy, slot_active;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    slotseq_ctrl #(.CYC_PER_US(CPU), .SETTLE_US(SET_US), .PLL_US(PLL_US),
                   .BUS_HALF(HALF), .BUS_HOLD(HOLD), .ENA_LEAD(LEAD)) uut (
        .clk(clk), .rst(rst), .start(start), .slot_tx(slot_tx),
        .clk_recov(clk_recov), .chan_code(chan_code), .pa_level(pa_level),
        .dev_trim(dev_trim), .tx_data_go(tx_data_go), .slot_end(slot_end),
        .pwr_reg_en(pwr_reg_en), .pwr_trx_en(pwr_trx_en), .rx_en(rx_en),
        .tx_en(tx_en), .open_loop_n(open_loop_n), .bus_clk(bus_clk),
        .bus_dat(bus_dat), .bus_en_n(bus_en_n), .busy(busy),
        .slot_active(slot_active)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected frame for the slot in flight
    logic [24:0] exp_word;
    int exp_len;
    string exp_tag;

    // bus-slave monitor, sampled on falling clock edges
    logic p_clk = 0, p_dat = 0, p_en_n = 1, p_pwr = 0, p_slot = 0;
    int pwr_cnt = 0, lcnt = 0, hcnt = 0, latch_cnt = 0, nbits = 0;
    bit framed = 0, latched = 0;
    logic [24:0] frame = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (pwr_trx_en && !p_pwr) begin pwr_cnt = 0; framed = 0; end
            if (pwr_trx_en && bus_en_n && !framed) pwr_cnt++;
            if (!bus_en_n && p_en_n) begin
                chk(pwr_cnt >= SET_C && pwr_cnt <= SET_C + 3, "R2 settle cycles", pwr_cnt, SET_C);
                framed = 1; lcnt = 0; nbits = 0; frame = 0;
            end
            if (!bus_en_n && !bus_clk) lcnt++;
            if (bus_clk) hcnt++;
            if (bus_clk && !p_clk) begin
                chk(lcnt >= ((nbits == 0) ? LEAD + HALF : HALF), "R6 low phase", lcnt, HALF);
                frame = {frame[23:0], bus_dat};
                nbits++;
                lcnt = 0;
            end
            if (bus_clk && p_clk && bus_dat != p_dat) chk(0, "R6 data moved while clock high", bus_dat, p_dat);
            if (!bus_clk && p_clk) begin
                chk(bus_dat == p_dat, "R6 hold after fall", bus_dat, p_dat);
                chk(hcnt >= HALF, "R6 high phase", hcnt, HALF);
                hcnt = 0;
            end
            if (bus_en_n && !p_en_n) begin
                chk(!bus_clk, "R6 clock low at latch", bus_clk, 0);
                chk(nbits == exp_len, {exp_tag, " frame length"}, nbits, exp_len);
                chk(frame == exp_word, {exp_tag, " frame value"}, frame, exp_word);
                latched = 1; latch_cnt = 0;
            end
            if (latched && !rx_en && !tx_en && pwr_trx_en) latch_cnt++;
            if (slot_active && !p_slot) begin
                chk(latch_cnt >= PLL_C && latch_cnt <= PLL_C + 3, "R7 lock wait", latch_cnt, PLL_C);
                latched = 0;
            end
            chk(slot_active == (rx_en || tx_en), "R12 active match", slot_active, rx_en || tx_en);
        end
        p_clk = bus_clk; p_dat = bus_dat; p_en_n = bus_en_n;
        p_pwr = pwr_trx_en; p_slot = slot_active;
    end

    task automatic run_slot(input bit tx, input bit rec, input logic [7:0] ch,
                            input logic [1:0] pa, input logic [2:0] dv, input bit poke);
        if (tx) begin
            exp_word = {9'b0, 2'b01, pa, dv, 1'b1, ch}; exp_len = 16; exp_tag = "R3";
        end else if (rec) begin
            exp_word = {9'b101000000, 8'h00, ch}; exp_len = 25; exp_tag = "R5";
        end else begin
            exp_word = {9'b0, 2'b01, 6'b0, ch}; exp_len = 16; exp_tag = "R4";
        end
        @(negedge clk);
        slot_tx = tx; clk_recov = rec; chan_code = ch; pa_level = pa; dev_trim = dv; start = 1;
        @(negedge clk);
        start = 0;
        chk(busy && pwr_reg_en && pwr_trx_en, "R2 power up", {busy, pwr_reg_en, pwr_trx_en}, 3'b111);
        chk(bus_en_n, "R2 bus quiet", bus_en_n, 1);
        while (!slot_active) @(negedge clk);
        chk(tx_en == tx && rx_en == !tx, tx ? "R8 only tx_en" : "R9 only rx_en", {tx_en, rx_en}, {tx, !tx});
        chk(open_loop_n, "R8 open loop high before data", open_loop_n, 1);
        if (poke) begin
            start = 1; slot_tx = !tx; clk_recov = 1; chan_code = ~ch;
            @(negedge clk);
            start = 0;
            chk(tx_en == tx && rx_en == !tx && busy, "R11 start ignored while busy", {tx_en, rx_en}, {tx, !tx});
        end
        repeat (4) @(negedge clk);
        tx_data_go = 1;
        @(negedge clk);
        tx_data_go = 0;
        chk(open_loop_n == !tx, tx ? "R8 open loop low" : "R9 open loop stays high", open_loop_n, !tx);
        repeat (3) @(negedge clk);
        chk(open_loop_n == !tx && slot_active, tx ? "R8 open loop held" : "R9 open loop held", open_loop_n, !tx);
        slot_end = 1;
        @(negedge clk);
        slot_end = 0;
        chk(!rx_en && !tx_en && open_loop_n && pwr_reg_en && pwr_trx_en, "R10 release before power",
            {rx_en, tx_en, open_loop_n, pwr_reg_en, pwr_trx_en}, 5'b00111);
        @(negedge clk);
        chk(!pwr_reg_en && !pwr_trx_en && !busy && !slot_active, "R10 power down",
            {pwr_reg_en, pwr_trx_en, busy}, 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(!pwr_trx_en && !busy && bus_en_n, "R11 no new power-up", {pwr_trx_en, busy}, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!pwr_reg_en && !pwr_trx_en && !rx_en && !tx_en && !bus_clk && !busy,
            "R1 reset lows", {pwr_reg_en, pwr_trx_en, rx_en, tx_en, bus_clk, busy}, 0);
        chk(open_loop_n && bus_en_n, "R1 reset highs", {open_loop_n, bus_en_n}, 2'b11);
        for (int p = 0; p < 4; p++)
            run_slot(1, p[0], 8'h5A ^ 8'(p * 37), 2'(p), 3'(2 * p + 1), 0);
        run_slot(1, 0, 8'hFF, 2'b11, 3'b000, 0);
        for (int c = 0; c < 4; c++) run_slot(0, 0, 8'(c * 85 + 1), 2'b11, 3'b111, 0);
        for (int c = 0; c < 4; c++) run_slot(0, 1, 8'(8'hC3 + c * 29), 2'b10, 3'b101, 0);
        run_slot(0, 0, 8'h80, 0, 0, 1);
        run_slot(1, 0, 8'h01, 2'b01, 3'b100, 1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule